// File: doc/BRIEF.md
# Serial Receiver with Line-Activity Wake-Up

This block receives asynchronous serial characters in the 8N1 format: one start bit, a parameterised number of data bits sent least significant bit first, and one stop bit. A divisor input sets the bit period in clock cycles. When a character completes, its data is stored in a holding register and the receive interrupt is raised. Software reads the data with a one-cycle read strobe, and that read drops the interrupt.

Software can also put the block into a watch mode. While watch mode is armed, character assembly is suspended and the block only looks for activity on the line. The first falling edge raises the receive interrupt and sends a single-cycle wake request to an external power controller. The holding register keeps its old, meaningless contents. The next rising edge disarms watch mode automatically and normal reception resumes. To wake the block cleanly, the sender should open with an all-zero character, such as a long break, so that no early rising edge disarms the mode in the middle of a frame.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, `idle_o`=1, `rx_irq_o`=0, `armed_o`=0, `wake_req_o`=0 and `frame_err_o`=0.
- R2: In normal mode, `baud_div_i` sets the clock cycles per bit. A character is assembled least significant bit first from samples taken at the bit centres. On completion it loads `rx_data_o` and sets `rx_irq_o`.
- R3: A start bit is confirmed by a sample at mid-bit. A low pulse shorter than half a bit produces no character and no interrupt, and the receiver returns to idle.
- R4: `frame_err_o` is updated at each character completion: 1 when the stop-bit sample is low, 0 when it is high.
- R5: A cycle with `data_rd_i`=1 clears `rx_irq_o`. If a new interrupt cause occurs in the same cycle, the interrupt stays set.
- R6: `idle_o` is 0 while a character is being assembled and 1 otherwise. It is 1 throughout an armed period, from the second armed cycle on.
- R7: Writing 1 through `arm_wr_i`/`arm_wdata_i` arms watch mode. While armed, line activity starts no character, and `rx_data_o` is not changed.
- R8: The first falling edge on the synchronised line while armed sets `rx_irq_o` and gives exactly one single-cycle `wake_req_o` pulse, three clock edges after the falling edge on `rxd_i`.
- R9: The first rising edge after that falling edge clears `armed_o`, and normal reception then resumes.
- R10: A rising edge seen while armed, with no falling edge yet in the current armed period, does not disarm the block. This covers the case where the line was already low when the block was armed.
- R11: A write through `arm_wr_i` takes priority over the automatic disarm in the same cycle. Writing 0 disarms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single always-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| baud_div_i | input | DIV_W | Clock cycles per bit, at least 4 |
| arm_wr_i | input | 1 | Write strobe for the watch-mode arm bit |
| arm_wdata_i | input | 1 | Value written to the arm bit |
| data_rd_i | input | 1 | Read strobe of the receive data register |
| rx_data_o | output | DATA_W | Receive data register |
| rx_irq_o | output | 1 | Receive interrupt flag |
| frame_err_o | output | 1 | Stop bit of the last character was low |
| idle_o | output | 1 | No character reception in progress |
| armed_o | output | 1 | Watch-mode arm bit |
| wake_req_o | output | 1 | One-cycle wake request |

## Verification
A wrong arm state shows up almost at once. A receiver that stays armed swallows the next character, and the scoreboard sees a missing item within one frame. A receiver that disarms too early misses the wake pulse in the three-edge window. A lost "falling edge seen" marker disarms on the first rising edge after arming; with the line low at arm time, that error shows up in `armed_o` within about four cycles. Bad bit counting or bad sample timing shows up as a wrong byte or a wrong frame error when that character completes.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;
endpackage

// File: rtl/uwr_sync.sv
module uwr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("uwr_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[i] <= 1'b1;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign q_o    = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~prev_q;
   assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/uwr_rx_core.sv
module uwr_rx_core
   import uwr_pkg::*;
#(
   parameter int DIV_W  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              rx_i,
   input  logic              fall_i,
   input  logic [DIV_W-1:0]  div_i,
   output logic              idle_o,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o,
   output logic              ferr_o
);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   rx_state_e         state_q;
   logic [DIV_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] shift_q;
   logic [DATA_W-1:0] data_q;
   logic              ferr_q;
   logic              done_q;
   logic [DIV_W-1:0]  full_ld;
   logic [DIV_W-1:0]  half_ld;
   logic              tick;

   assign full_ld = div_i - DIV_W'(1);
   assign half_ld = (div_i >> 1) - DIV_W'(1);
   assign tick    = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         shift_q <= '0;
         data_q  <= '0;
         ferr_q  <= 1'b0;
         done_q  <= 1'b0;
      end else if (!en_i) begin
         state_q <= RX_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            RX_IDLE: begin
               if (fall_i) begin
                  state_q <= RX_START;
                  cnt_q   <= half_ld;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (!rx_i) begin
                     state_q <= RX_DATA;
                     cnt_q   <= full_ld;
                     idx_q   <= '0;
                  end else begin
                     state_q <= RX_IDLE;
                  end
               end else begin
                  cnt_q <= cnt_q - DIV_W'(1);
               end
            end
            RX_DATA: begin
               if (tick) begin
                  shift_q <= {rx_i, shift_q[DATA_W-1:1]};
                  cnt_q   <= full_ld;
                  idx_q   <= idx_q + IDX_W'(1);
                  if (idx_q == LAST_IDX) state_q <= RX_STOP;
               end else begin
                  cnt_q <= cnt_q - DIV_W'(1);
               end
            end
            RX_STOP: begin
               if (tick) begin
                  data_q  <= shift_q;
                  ferr_q  <= ~rx_i;
                  done_q  <= 1'b1;
                  state_q <= RX_IDLE;
               end else begin
                  cnt_q <= cnt_q - DIV_W'(1);
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   assign idle_o = (state_q == RX_IDLE);
   assign done_o = done_q;
   assign data_o = data_q;
   assign ferr_o = ferr_q;
endmodule

// File: rtl/uwr_wake_mon.sv
module uwr_wake_mon (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   input  logic wdata_i,
   input  logic rise_i,
   input  logic fall_i,
   output logic armed_o,
   output logic seen_o,
   output logic hit_o,
   output logic pulse_o
);
   logic armed_q;
   logic seen_q;
   logic pulse_q;

   assign hit_o = armed_q & fall_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         seen_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= hit_o;
         if (wr_i) begin
            armed_q <= wdata_i;
            seen_q  <= 1'b0;
         end else if (armed_q) begin
            if (fall_i) begin
               seen_q <= 1'b1;
            end else if (seen_q && rise_i) begin
               armed_q <= 1'b0;
               seen_q  <= 1'b0;
            end
         end
      end
   end

   assign armed_o = armed_q;
   assign seen_o  = seen_q;
   assign pulse_o = pulse_q;
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
   parameter int DIV_W       = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd_i,
   input  logic [DIV_W-1:0]  baud_div_i,
   input  logic              arm_wr_i,
   input  logic              arm_wdata_i,
   input  logic              data_rd_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_irq_o,
   output logic              frame_err_o,
   output logic              idle_o,
   output logic              armed_o,
   output logic              wake_req_o
);
   generate
      if (DIV_W < 3) begin : g_bad_div
         $error("uart_wake_rx: DIV_W must be at least 3");
      end
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_data
         $error("uart_wake_rx: DATA_W must be 5 to 9");
      end
   endgenerate

   logic sync_q;
   logic sync_rise;
   logic sync_fall;
   logic mon_seen;
   logic mon_hit;
   logic core_done;
   logic core_idle;
   logic irq_q;

   uwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (rxd_i),
      .q_o    (sync_q),
      .rise_o (sync_rise),
      .fall_o (sync_fall)
   );

   uwr_wake_mon u_mon (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (arm_wr_i),
      .wdata_i (arm_wdata_i),
      .rise_i  (sync_rise),
      .fall_i  (sync_fall),
      .armed_o (armed_o),
      .seen_o  (mon_seen),
      .hit_o   (mon_hit),
      .pulse_o (wake_req_o)
   );

   uwr_rx_core #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (~armed_o),
      .rx_i   (sync_q),
      .fall_i (sync_fall),
      .div_i  (baud_div_i),
      .idle_o (core_idle),
      .done_o (core_done),
      .data_o (rx_data_o),
      .ferr_o (frame_err_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                    irq_q <= 1'b0;
      else if (mon_hit || core_done) irq_q <= 1'b1;
      else if (data_rd_i)            irq_q <= 1'b0;
   end

   assign rx_irq_o = irq_q;
   assign idle_o   = core_idle;
endmodule

// File: rtl/uwr_checker.sv
module uwr_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              arm_wr_i,
   input logic              arm_wdata_i,
   input logic              data_rd_i,
   input logic              armed_o,
   input logic              idle_o,
   input logic              rx_irq_o,
   input logic              wake_req_o,
   input logic [DATA_W-1:0] rx_data_o,
   input logic              fall,
   input logic              rise,
   input logic              seen,
   input logic              done
);
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (!armed_o && !rx_irq_o && !wake_req_o && idle_o));

   assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd_i && !(armed_o && fall) && !done) |=> !rx_irq_o);

   assert_armed_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_o && $past(armed_o)) |-> idle_o);

   assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_o && $past(armed_o)) |-> $stable(rx_data_o));

   assert_wake_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_o && fall) |=> (wake_req_o && rx_irq_o));

   assert_wake_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req_o |=> !wake_req_o);

   assert_autoclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_o && seen && rise && !arm_wr_i) |=> !armed_o);

   assert_hold_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_o && !seen && !arm_wr_i) |=> armed_o);

   assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      arm_wr_i |=> (armed_o == $past(arm_wdata_i)));
endmodule

bind uart_wake_rx uwr_checker #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .arm_wr_i    (arm_wr_i),
   .arm_wdata_i (arm_wdata_i),
   .data_rd_i   (data_rd_i),
   .armed_o     (armed_o),
   .idle_o      (idle_o),
   .rx_irq_o    (rx_irq_o),
   .wake_req_o  (wake_req_o),
   .rx_data_o   (rx_data_o),
   .fall        (sync_fall),
   .rise        (sync_rise),
   .seen        (mon_seen),
   .done        (core_done)
);

// File: tb/sim_uart_wake_rx.sv
module sim_uart_wake_rx;
   localparam int BIT = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rxd = 1'b1;
   logic        arm_wr = 1'b0;
   logic        arm_wd = 1'b0;
   logic        rd_mon = 1'b0;
   logic        rd_man = 1'b0;
   logic [15:0] div = 16'(BIT);
   logic [7:0]  rx_data;
   logic        irq, ferr, idle, armed, wake;

   int checks = 0;
   int fails = 0;
   int wake_cnt = 0;
   bit mon_en = 1'b0;
   logic [7:0] last_data = 8'h00;
   logic [8:0] exp_q[$];

   always #4 clk = ~clk;

   uart_wake_rx u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .rxd_i       (rxd),
      .baud_div_i  (div),
      .arm_wr_i    (arm_wr),
      .arm_wdata_i (arm_wd),
      .data_rd_i   (rd_mon | rd_man),
      .rx_data_o   (rx_data),
      .rx_irq_o    (irq),
      .frame_err_o (ferr),
      .idle_o      (idle),
      .armed_o     (armed),
      .wake_req_o  (wake)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) if (wake) wake_cnt++;

   // scoreboard monitor: pops the expected item when the interrupt rises
   initial begin
      forever begin
         @(negedge clk);
         if (rd_mon) begin
            rd_mon = 1'b0;
         end else if (mon_en && irq) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2 unexpected character", int'(rx_data), 0);
            end else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               check(rx_data == e[7:0], "R2 data", int'(rx_data), int'(e[7:0]));
               check(ferr == e[8], "R4 frame error", int'(ferr), int'(e[8]));
               last_data = e[7:0];
            end
            rd_mon = 1'b1;
         end
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit stop);
      exp_q.push_back({~stop, b});
      rxd = 1'b0;
      wait_n(BIT);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         wait_n(BIT / 2);
         if (i == 0) check(idle == 1'b0, "R6 busy during frame", int'(idle), 0);
         wait_n(BIT - BIT / 2);
      end
      rxd = stop;
      wait_n(BIT);
      rxd = 1'b1;
      wait_n(BIT);
   endtask

   task automatic write_arm(input bit v);
      arm_wr = 1'b1;
      arm_wd = v;
      wait_n(1);
      arm_wr = 1'b0;
   endtask

   task automatic read_data();
      rd_man = 1'b1;
      wait_n(1);
      rd_man = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int w0;
      wait_n(4);
      rst_n = 1'b1;
      wait_n(1);
      check(idle == 1'b1 && irq == 1'b0, "R1 idle/irq", int'({idle, irq}), 2);
      check(armed == 1'b0 && wake == 1'b0 && ferr == 1'b0, "R1 armed/wake/ferr",
            int'({armed, wake, ferr}), 0);
      mon_en = 1'b1;

      // R2, R4: normal characters
      send_byte(8'h55, 1'b1);
      send_byte(8'hA3, 1'b1);
      send_byte(8'h01, 1'b1);
      send_byte(8'h80, 1'b0);
      send_byte(8'hFF, 1'b1);
      send_byte(8'h00, 1'b1);

      // R3: short glitch rejected
      rxd = 1'b0;
      wait_n(2);
      rxd = 1'b1;
      wait_n(3 * BIT);
      check(irq == 1'b0, "R3 glitch irq", int'(irq), 0);
      check(idle == 1'b1, "R3 glitch idle", int'(idle), 1);

      // R7, R8, R9: wake on break
      wait_n(4);
      mon_en = 1'b0;
      write_arm(1'b1);
      check(armed == 1'b1, "R7 armed", int'(armed), 1);
      w0 = wake_cnt;
      rxd = 1'b0;
      wait_n(6);
      check(wake_cnt == w0 + 1, "R8 wake pulse", wake_cnt - w0, 1);
      check(irq == 1'b1, "R8 irq set", int'(irq), 1);
      wait_n(12 * BIT);
      check(wake_cnt == w0 + 1, "R8 single pulse", wake_cnt - w0, 1);
      check(armed == 1'b1 && idle == 1'b1, "R6 R7 armed idle", int'({armed, idle}), 3);
      check(rx_data == last_data, "R7 data kept", int'(rx_data), int'(last_data));
      rxd = 1'b1;
      wait_n(5);
      check(armed == 1'b0, "R9 autoclear", int'(armed), 0);
      read_data();
      check(irq == 1'b0, "R5 read clears irq", int'(irq), 0);
      mon_en = 1'b1;
      send_byte(8'h3C, 1'b1);   // R9 normal reception resumes

      // R10: line already low when armed
      exp_q.push_back({1'b1, 8'h00});
      rxd = 1'b0;
      wait_n(12 * BIT);
      check(exp_q.size() == 0, "R4 break character", exp_q.size(), 0);
      wait_n(4);
      mon_en = 1'b0;
      write_arm(1'b1);
      w0 = wake_cnt;
      rxd = 1'b1;
      wait_n(6);
      check(armed == 1'b1, "R10 no early disarm", int'(armed), 1);
      check(wake_cnt == w0, "R10 no wake on rise", wake_cnt - w0, 0);
      rxd = 1'b0;
      wait_n(6);
      check(wake_cnt == w0 + 1, "R8 wake after arm", wake_cnt - w0, 1);
      rxd = 1'b1;
      wait_n(6);
      check(armed == 1'b0, "R9 disarm on rise", int'(armed), 0);
      read_data();

      // R11: write in same cycle as autoclear wins
      write_arm(1'b1);
      rxd = 1'b0;
      wait_n(6);
      rxd = 1'b1;
      wait_n(2);
      arm_wr = 1'b1;
      arm_wd = 1'b1;
      wait_n(1);
      arm_wr = 1'b0;
      check(armed == 1'b1, "R11 write wins", int'(armed), 1);
      wait_n(4);
      check(armed == 1'b1, "R11 stays armed", int'(armed), 1);
      write_arm(1'b0);
      check(armed == 1'b0, "R11 write zero", int'(armed), 0);
      read_data();
      check(irq == 1'b0, "R5 irq cleared", int'(irq), 0);

      mon_en = 1'b1;
      send_byte(8'hC6, 1'b1);
      wait_n(4);
      check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule